// File: doc/BRIEF.md
# Multicycle 32-bit Load/Store Processor Core

This core executes a four-instruction subset of a classic 32-bit load/store
instruction set by stepping each instruction through a short sequence of
clock cycles. One adder/logic unit and one memory port serve every step. The
instruction word, the two source operands, the unit's result and the loaded
memory word are each held in a dedicated register between steps, because the
shared logic's inputs change from one cycle to the next.

The control sequencer walks through fetch, decode, execute, memory/completion
and load write-back. Branches finish after three cycles, stores and register
operations after four, and loads after five. During decode the unit speculatively
forms the branch target, so a taken branch only has to copy it into the PC. The
core talks to a single synchronous memory whose read data is valid in the same
cycle as the address. The PC and a register-file write strobe are brought out for
observation.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and puts the sequencer in the fetch step; the first cycle after reset reads memory at address 0 with read enable high.
- R2: A fetch reads the word at the PC into the instruction register and advances the PC by 4, using the shared unit; the PC is visible as the new value one cycle later.
- R3: Opcode 000000 selects a register operation through the low six bits: 100000 add, 100010 subtract, 100100 AND, 100101 OR. It reads registers at bits 25-21 and 20-16, writes the result to the register at bits 15-11 and takes 4 cycles.
- R4: Register operation with low bits 101010 writes 1 when the first operand is below the second as signed 32-bit values, else 0.
- R5: Opcode 100011 reads memory at register[25-21] plus the sign-extended bits 15-0 and writes the word to the register at bits 20-16; it takes 5 cycles, negative offsets included.
- R6: Opcode 101011 writes register[20-16] to memory at register[25-21] plus the sign-extended offset and takes 4 cycles.
- R7: Opcode 000100 compares registers[25-21] and [20-16]; when equal the next fetch is at PC+4 plus the sign-extended offset times 4, otherwise at PC+4. It takes 3 cycles.
- R8: Register 0 always reads as zero and writes to it have no effect.
- R9: Any other opcode returns to fetch after the decode cycle (2 cycles in all) with no register or memory write, and the next fetch is at PC+4.
- R10: Read and write enables are never high together; the register write strobe pulses exactly once, in the last cycle, for register operations and loads, and never for other instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address for the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the cycle the address is presented |
| mem_rd | output | 1 | Read enable (fetch or load) |
| mem_wr | output | 1 | Write enable (store) |
| dbg_pc | output | 32 | Current program counter |
| dbg_rf_we | output | 1 | Register-file write strobe |

## Verification
The assertions take for granted that reset is held high on the first clock edges, and that the memory answers a read combinationally in the same cycle, so the instruction captured in fetch is the word at the PC. They also rely on every program address and data address being word aligned. The stimulus keeps to this: the bench memory model returns data combinationally, all offsets and base registers used for loads and stores form aligned addresses, and code is placed below the data regions so fetches and data reads can be told apart by address.

// File: rtl/mc_pkg.sv
package mc_pkg;

   localparam logic [5:0] OP_REG   = 6'b000000;
   localparam logic [5:0] OP_LOAD  = 6'b100011;
   localparam logic [5:0] OP_STORE = 6'b101011;
   localparam logic [5:0] OP_BREQ  = 6'b000100;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [1:0] {
      AC_ADD   = 2'b00,
      AC_CMP   = 2'b01,
      AC_FUNCT = 2'b10
   } alu_class_e;

   typedef enum logic [2:0] {
      AL_AND = 3'b000,
      AL_OR  = 3'b001,
      AL_ADD = 3'b010,
      AL_SUB = 3'b110,
      AL_SLT = 3'b111
   } alu_code_e;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_EXEC,
      ST_MEMWB,
      ST_LDWB
   } state_e;

   typedef enum logic {
      SA_PC,
      SA_REGA
   } srca_e;

   typedef enum logic [1:0] {
      SB_REGB,
      SB_STEP,
      SB_IMM,
      SB_OFFS
   } srcb_e;

   typedef struct packed {
      logic       ir_we;
      logic       pc_we;
      logic       pc_br;
      logic       ab_we;
      logic       out_we;
      logic       mdr_we;
      logic       rf_we;
      logic       rf_from_mem;
      logic       rf_dst_rd;
      logic       mem_rd;
      logic       mem_wr;
      logic       addr_from_out;
      srca_e      srca;
      srcb_e      srcb;
      alu_class_e aluop;
   } ctrl_t;

endpackage

// File: rtl/mc_alu_ctrl.sv
module mc_alu_ctrl
   import mc_pkg::*;
(
   input  alu_class_e  cls,
   input  logic [5:0]  funct,
   output alu_code_e   code
);

   always_comb begin
      unique case (cls)
         AC_ADD: code = AL_ADD;
         AC_CMP: code = AL_SUB;
         default: begin
            case (funct)
               FN_ADD:  code = AL_ADD;
               FN_SUB:  code = AL_SUB;
               FN_AND:  code = AL_AND;
               FN_OR:   code = AL_OR;
               FN_SLT:  code = AL_SLT;
               default: code = AL_ADD;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_code_e    code,
   output logic [W-1:0] y,
   output logic         zero
);

   always_comb begin
      case (code)
         AL_AND:  y = a & b;
         AL_OR:   y = a | b;
         AL_SUB:  y = a - b;
         AL_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W          = 32,
   parameter int NREG       = 32,
   parameter bit RESET_REGS = 1'b1,
   localparam int AW        = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   input  logic [AW-1:0] wa,
   input  logic          we,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2
);

   logic [W-1:0] regs [NREG];

   generate
      if (RESET_REGS) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (we && wa != '0) begin
               regs[wa] <= wd;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && wa != '0) regs[wa] <= wd;
         end
      end
   endgenerate

   assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
   assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [5:0] opcode,
   output state_e     state,
   output ctrl_t      ctl
);

   state_e nxt;
   logic   known;

   assign known = (opcode == OP_REG) || (opcode == OP_LOAD) ||
                  (opcode == OP_STORE) || (opcode == OP_BREQ);

   always_ff @(posedge clk) begin
      if (rst) state <= ST_FETCH;
      else     state <= nxt;
   end

   always_comb begin
      ctl       = '0;
      ctl.srca  = SA_PC;
      ctl.srcb  = SB_STEP;
      ctl.aluop = AC_ADD;
      nxt       = ST_FETCH;
      case (state)
         ST_FETCH: begin
            ctl.mem_rd = 1'b1;
            ctl.ir_we  = 1'b1;
            ctl.pc_we  = 1'b1;
            nxt        = ST_DECODE;
         end
         ST_DECODE: begin
            if (known) begin
               ctl.ab_we  = 1'b1;
               ctl.out_we = 1'b1;
               ctl.srcb   = SB_OFFS;
               nxt        = ST_EXEC;
            end
         end
         ST_EXEC: begin
            ctl.srca = SA_REGA;
            if (opcode == OP_BREQ) begin
               ctl.srcb  = SB_REGB;
               ctl.aluop = AC_CMP;
               ctl.pc_br = 1'b1;
            end else if (opcode == OP_REG) begin
               ctl.srcb   = SB_REGB;
               ctl.aluop  = AC_FUNCT;
               ctl.out_we = 1'b1;
               nxt        = ST_MEMWB;
            end else begin
               ctl.srcb   = SB_IMM;
               ctl.out_we = 1'b1;
               nxt        = ST_MEMWB;
            end
         end
         ST_MEMWB: begin
            if (opcode == OP_REG) begin
               ctl.rf_we     = 1'b1;
               ctl.rf_dst_rd = 1'b1;
            end else if (opcode == OP_LOAD) begin
               ctl.mem_rd        = 1'b1;
               ctl.addr_from_out = 1'b1;
               ctl.mdr_we        = 1'b1;
               nxt               = ST_LDWB;
            end else begin
               ctl.mem_wr        = 1'b1;
               ctl.addr_from_out = 1'b1;
            end
         end
         ST_LDWB: begin
            ctl.rf_we       = 1'b1;
            ctl.rf_from_mem = 1'b1;
         end
         default: nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NREG     = 32,
   parameter bit RF_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [XLEN-1:0] dbg_pc,
   output logic            dbg_rf_we
);

   localparam int RAW   = $clog2(NREG);
   localparam int STEP  = XLEN / 8;
   localparam int IMM_W = 16;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mc_core: instruction format needs XLEN of 32");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("mc_core: register fields address exactly 32 registers");
      end
   endgenerate

   state_e state_q;
   ctrl_t  ctl;

   logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, out_q, mdr_q;
   logic [XLEN-1:0] rd1, rd2, src_a, src_b, alu_y, imm_x, offs_x, wd;
   logic            alu_zero;
   alu_code_e       code;
   logic [RAW-1:0]  wa;

   wire [5:0]     f_op    = ir_q[31:26];
   wire [RAW-1:0] f_rs    = ir_q[25:21];
   wire [RAW-1:0] f_rt    = ir_q[20:16];
   wire [RAW-1:0] f_rd    = ir_q[15:11];
   wire [5:0]     f_funct = ir_q[5:0];

   assign imm_x  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign offs_x = {imm_x[XLEN-3:0], 2'b00};

   mc_ctrl i_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (f_op),
      .state  (state_q),
      .ctl    (ctl)
   );

   mc_regfile #(.W(XLEN), .NREG(NREG), .RESET_REGS(RF_RESET)) i_rf (
      .clk (clk),
      .rst (rst),
      .ra1 (f_rs),
      .ra2 (f_rt),
      .wa  (wa),
      .we  (ctl.rf_we),
      .wd  (wd),
      .rd1 (rd1),
      .rd2 (rd2)
   );

   mc_alu_ctrl i_aluc (
      .cls   (ctl.aluop),
      .funct (f_funct),
      .code  (code)
   );

   always_comb begin
      src_a = (ctl.srca == SA_REGA) ? a_q : pc_q;
      case (ctl.srcb)
         SB_REGB: src_b = b_q;
         SB_IMM:  src_b = imm_x;
         SB_OFFS: src_b = offs_x;
         default: src_b = XLEN'(STEP);
      endcase
   end

   mc_alu #(.W(XLEN)) i_alu (
      .a    (src_a),
      .b    (src_b),
      .code (code),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign wa = ctl.rf_dst_rd ? f_rd : f_rt;
   assign wd = ctl.rf_from_mem ? mdr_q : out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         ir_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         out_q <= '0;
         mdr_q <= '0;
      end else begin
         if (ctl.ir_we) ir_q <= mem_rdata;
         if (ctl.pc_we) pc_q <= alu_y;
         else if (ctl.pc_br && alu_zero) pc_q <= out_q;
         if (ctl.ab_we) begin
            a_q <= rd1;
            b_q <= rd2;
         end
         if (ctl.out_we) out_q <= alu_y;
         if (ctl.mdr_we) mdr_q <= mem_rdata;
      end
   end

   assign mem_addr  = ctl.addr_from_out ? out_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign dbg_pc    = pc_q;
   assign dbg_rf_we = ctl.rf_we;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
   import mc_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input state_e      state,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic [31:0] mem_addr,
   input logic [31:0] dbg_pc,
   input logic        dbg_rf_we
);

   AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (dbg_pc == 32'd0 && state == ST_FETCH)); // R1

   AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
      state == ST_FETCH |-> (mem_rd && !mem_wr && mem_addr == dbg_pc)); // R2

   AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      state == ST_FETCH |=> dbg_pc == $past(dbg_pc) + 32'd4); // R2

   AST_PC_HELD: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DECODE || state == ST_MEMWB || state == ST_LDWB) |=> $stable(dbg_pc)); // R7

   AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
      state == ST_LDWB |-> ($past(mem_rd) && $past(state) == ST_MEMWB)); // R5

   AST_STORE_ENDS: assert property (@(posedge clk) disable iff (rst)
      mem_wr |=> state == ST_FETCH); // R6

   AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr)); // R10

   AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (rst)
      dbg_rf_we |=> state == ST_FETCH); // R10

endmodule

bind mc_core mc_core_chk i_chk (
   .clk       (clk),
   .rst       (rst),
   .state     (state_q),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_addr  (mem_addr),
   .dbg_pc    (dbg_pc),
   .dbg_rf_we (dbg_rf_we)
);

// File: tb/test_mc_core.sv
`timescale 1ns/1ps
module test_mc_core;

   localparam logic [5:0] OPR = 6'b000000, OPL = 6'b100011, OPS = 6'b101011, OPB = 6'b000100;
   localparam logic [5:0] FADD = 6'b100000, FSUB = 6'b100010, FAND = 6'b100100,
                          FOR = 6'b100101, FSLT = 6'b101010;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_pc;
   logic        mem_rd, mem_wr, dbg_rf_we;

   always #4 clk = ~clk;

   mc_core i_mc_core (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .dbg_pc    (dbg_pc),
      .dbg_rf_we (dbg_rf_we)
   );

   logic [31:0] img [0:1023];
   logic [31:0] mem [0:1023];
   logic [31:0] dm  [0:1023];

   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 1024; i++) mem[i] <= img[i];
      end else if (mem_wr) begin
         mem[mem_addr[11:2]] <= mem_wdata;
      end
   end

   int          checks = 0, errors = 0;
   bit          reported = 0;
   logic [31:0] mreg [0:31];
   string       rtag [0:31];
   int          e_len [0:255];
   int          e_we  [0:255];
   logic [31:0] e_nxt [0:255];
   string       e_tag [0:255];
   int          wp;
   logic [31:0] halt_addr;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
      return {OPR, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
      case (fn)
         FADD:    return a + b;
         FSUB:    return a - b;
         FAND:    return a & b;
         FOR:     return a | b;
         default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
   endfunction

   function automatic logic [5:0] pick_fn(int k);
      case (k % 5)
         0: return FADD;
         1: return FSUB;
         2: return FAND;
         3: return FOR;
         default: return FSLT;
      endcase
   endfunction

   task automatic put(input logic [31:0] w, input int len, input int we, input int step, input string tag);
      img[wp]   = w;
      e_len[wp] = len;
      e_we[wp]  = we;
      e_nxt[wp] = wp * 4 + step;
      e_tag[wp] = tag;
      wp++;
   endtask

   task automatic op_r(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] rs,
                       input logic [4:0] rt, input bit live);
      put(enc_r(fn, rd, rs, rt), 4, 1, 4, (fn == FSLT) ? "R4" : "R3");
      if (live && rd != 0) begin
         mreg[rd] = ref_alu(fn, mreg[rs], mreg[rt]);
         rtag[rd] = (fn == FSLT) ? "R4" : "R3";
      end
   endtask

   task automatic op_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
      logic [31:0] ad;
      ad = mreg[rs] + {{16{imm[15]}}, imm};
      put(enc_i(OPL, rs, rt, imm), 5, 1, 4, "R5");
      if (rt != 0) begin
         mreg[rt] = dm[ad[11:2]];
         rtag[rt] = "R5";
      end
   endtask

   task automatic op_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
      logic [31:0] ad;
      ad = mreg[rs] + {{16{imm[15]}}, imm};
      put(enc_i(OPS, rs, rt, imm), 4, 0, 4, "R6");
      dm[ad[11:2]] = mreg[rt];
   endtask

   task automatic op_beq(input logic [4:0] rs, input logic [4:0] rt, output bit taken);
      taken = (mreg[rs] == mreg[rt]);
      put(enc_i(OPB, rs, rt, 16'd1), 3, 0, taken ? 8 : 4, "R7");
   endtask

   // monitor: fetch-to-fetch timing, next address, write strobes
   int          cyc = 0, prev_cyc = 0, we_cnt = 0, pidx = 0;
   bit          have_prev = 0, done = 0, rw_bad = 0, step_due = 0;
   logic [31:0] paddr = 0;

   always @(negedge clk) begin
      if (!rst && !done) begin
         cyc++;
         if (mem_rd && mem_wr) rw_bad = 1;
         if (step_due) begin
            chk(dbg_pc == paddr + 32'd4, "R2", "pc after fetch", dbg_pc, paddr + 32'd4);
            step_due = 0;
         end
         if (mem_rd && mem_addr == dbg_pc && mem_addr < 32'h400) begin
            if (have_prev) begin
               chk(cyc - prev_cyc == e_len[pidx], e_tag[pidx], "cycle count",
                   32'(cyc - prev_cyc), 32'(e_len[pidx]));
               chk(mem_addr == e_nxt[pidx], (e_tag[pidx] == "R9") ? "R9" : "R7",
                   "next fetch address", mem_addr, e_nxt[pidx]);
               chk(we_cnt == e_we[pidx], "R10", "write strobe count",
                   32'(we_cnt), 32'(e_we[pidx]));
            end
            have_prev = 1;
            pidx      = int'(mem_addr[9:2]);
            paddr     = mem_addr;
            prev_cyc  = cyc;
            we_cnt    = 0;
            step_due  = 1;
            if (mem_addr == halt_addr) done = 1;
         end
         if (dbg_rf_we) we_cnt++;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
      report();
   end

   initial begin
      bit t;
      void'($urandom(32'd4242));
      for (int i = 0; i < 1024; i++) begin img[i] = 32'd0; dm[i] = 32'd0; end
      for (int i = 0; i < 32; i++) begin mreg[i] = 32'd0; rtag[i] = "R8"; end
      img[256] = 32'h8000_0000; img[257] = 32'h7FFF_FFFF; img[258] = 32'hFFFF_FFFF;
      img[259] = 32'd5;         img[260] = 32'h1234_5678; img[261] = 32'h0F0F_0F0F;
      img[262] = 32'hDEAD_BEEF; img[263] = 32'h0000_0420;
      for (int i = 256; i < 264; i++) dm[i] = img[i];
      wp = 0;
      // R5: loads with base r0, then a negative offset through a pointer
      for (int i = 1; i <= 8; i++) op_lw(5'(i), 5'd0, 16'(32'h400 + 4 * (i - 1)));
      op_lw(5'd9, 5'd8, 16'hFFF8);
      // R4: signed compare corners
      op_r(FSLT, 5'd10, 5'd1, 5'd2, 1);
      op_r(FSLT, 5'd11, 5'd2, 5'd1, 1);
      op_r(FSLT, 5'd12, 5'd3, 5'd4, 1);
      // R8: write to r0 dropped, r0 reads as zero
      op_r(FADD, 5'd0, 5'd1, 5'd2, 1);
      op_r(FADD, 5'd13, 5'd0, 5'd4, 1);
      op_r(FSUB, 5'd14, 5'd1, 5'd2, 1);
      // R7: taken then not taken
      op_beq(5'd3, 5'd3, t);
      op_r(FADD, 5'd13, 5'd1, 5'd1, !t);
      op_beq(5'd1, 5'd2, t);
      op_r(FOR, 5'd15, 5'd5, 5'd6, !t);
      // R9: unsupported opcode
      put(32'hFC0F_FFFF, 2, 0, 4, "R9");
      // constrained random mix
      for (int n = 0; n < 80; n++) begin
         int k;
         logic [4:0] rs, rt, rd;
         k  = int'($urandom % 10);
         rs = 5'(1 + $urandom % 15);
         rt = 5'(1 + $urandom % 15);
         rd = 5'($urandom % 16);
         if (k == 0) op_sw(rs, 5'd0, 16'(32'h500 + 4 * ($urandom % 16)));
         else if (k == 1) op_lw(rd, 5'd0, 16'(32'h500 + 4 * ($urandom % 16)));
         else if (k == 2) begin
            if ($urandom % 2 == 0) rt = rs;
            op_beq(rs, rt, t);
            op_r(pick_fn(int'($urandom % 5)), rd, rs, rt, !t);
         end else op_r(pick_fn(int'($urandom % 5)), rd, rs, rt, 1);
      end
      // R6: dump r0..r15
      for (int i = 0; i < 16; i++) op_sw(5'(i), 5'd0, 16'(32'h600 + 4 * i));
      halt_addr = 32'(wp * 4);
      put(enc_i(OPB, 5'd0, 5'd0, 16'hFFFF), 3, 0, 0, "R7");

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
      chk(!mem_wr && !dbg_rf_we, "R1", "no writes in reset", {30'd0, mem_wr, dbg_rf_we}, 32'd0);
      @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(mem_rd && mem_addr == 32'd0, "R1", "first fetch address", mem_addr, 32'd0);

      wait (done);
      repeat (6) @(negedge clk);
      for (int i = 0; i < 16; i++)
         chk(mem[384 + i] == mreg[i], rtag[i], $sformatf("stored r%0d", i), mem[384 + i], mreg[i]);
      for (int i = 320; i < 336; i++)
         chk(mem[i] == dm[i], "R6", $sformatf("scratch word %0d", i), mem[i], dm[i]);
      for (int i = 256; i < 264; i++)
         chk(mem[i] == img[i], "R9", $sformatf("data word %0d untouched", i), mem[i], img[i]);
      chk(!rw_bad, "R10", "read and write never together", {31'd0, rw_bad}, 32'd0);
      report();
   end

endmodule